// File: doc/BRIEF.md
# ADC Result Conditioner with Window Monitor

This block sits between an ADC core and the result register. Each raw sample can be corrected for offset and gain, cut down to 16, 12, 10 or 8 significant bits, and either right-aligned or left-aligned in a 16-bit word. A window comparator then checks the right-aligned value against a lower and an upper threshold and raises a flag.

The comparator has five settings: off, above the lower threshold, below the upper threshold, strictly inside the window, and strictly inside an inverted window. Correction adds a fixed latency. While a corrected sample is still being processed, the block drops any new sample and reports an overrun. The control inputs are meant to be held stable while a sample is in flight.

Top module: `adc_result_conditioner`

## Requirements
- R1: After reset, `res_vld`, `res_data`, `win_hit` and `overrun` are all zero.
- R2: With `corr_en`=0, a sample accepted on a rising edge produces `res_vld`=1 for one cycle right after that edge. With `res_sel`=0 (12-bit), `res_data` = {4'b0, raw[11:0]}.
- R3: `res_sel` selects the right-aligned width. 0 gives raw[11:0]. 1 gives all 16 raw bits. 2 gives raw[11:0]>>2 (10 bits). 3 gives raw[11:0]>>4 (8 bits).
- R4: With `left_adj`=1, the reduced value is shifted so that its MSB lands on bit 15, and the bits below it are zero. In 16-bit mode the value is unchanged.
- R5: With `corr_en`=1, the value is (x − offset) × gain / 2^11, rounded down. Here `corr_off` is a signed 12-bit offset and `corr_gain` is an unsigned 12-bit gain with 11 fraction bits. The result is clamped to 0 at the bottom and to 0xFFF (0xFFFF in 16-bit mode) at the top, and this happens before resolution reduction.
- R6: With `corr_en`=1, `res_vld` rises exactly 13 cycles later than it would on the uncorrected path, and it stays low in between.
- R7: Code 1 of `win_mode` flags when result > `win_lo`. Code 2 flags when result < `win_hi`.
- R8: Code 3 flags when `win_lo` < result < `win_hi`. Code 4 flags when `win_hi` < result < `win_lo`. All comparisons are strict.
- R9: Codes 0, 5, 6 and 7 of `win_mode` never raise `win_hit`.
- R10: A sample that arrives while a corrected sample is in flight is dropped. This holds up to and including the edge on which the in-flight result is delivered. `overrun` pulses in the cycle after the drop, and the dropped sample produces no result.
- R11: The window test uses the right-aligned reduced value even when `left_adj`=1. `win_hit` is high only together with `res_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_vld | input | 1 | Raw sample strobe |
| raw_data | input | 16 | Raw sample (12-bit modes use bits 11:0) |
| win_mode | input | 3 | Window comparator setting |
| res_sel | input | 2 | Resolution select |
| corr_en | input | 1 | Enable gain/offset correction |
| left_adj | input | 1 | Left-align the result |
| corr_gain | input | 12 | Unsigned gain, 11 fraction bits |
| corr_off | input | 12 | Signed offset |
| win_lo | input | 16 | Lower threshold |
| win_hi | input | 16 | Upper threshold |
| res_data | output | 16 | Result word |
| res_vld | output | 1 | Result-ready strobe |
| win_hit | output | 1 | Window flag, aligned with res_vld |
| overrun | output | 1 | Dropped-sample pulse |

## Verification
Two events can fall on the same edge: delivery of a corrected result and arrival of the next sample. The bench produces this by driving a new sample so that it is captured on the thirteenth in-flight edge. It then expects `res_vld` and `overrun` high together, `res_data` equal to the first sample's corrected value, and no second result afterwards. A second drop in the middle of the latency window is checked the same way. In that case `overrun` must pulse while `res_vld` stays low.

// File: rtl/adc_result_conditioner.sv
module adc_result_conditioner #(
  parameter int CORR_LAT  = 13,
  parameter int GAIN_FRAC = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        raw_vld,
  input  logic [15:0] raw_data,
  input  logic [2:0]  win_mode,
  input  logic [1:0]  res_sel,
  input  logic        corr_en,
  input  logic        left_adj,
  input  logic [11:0] corr_gain,
  input  logic [11:0] corr_off,
  input  logic [15:0] win_lo,
  input  logic [15:0] win_hi,
  output logic [15:0] res_data,
  output logic        res_vld,
  output logic        win_hit,
  output logic        overrun
);

  localparam int CW = $clog2(CORR_LAT + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [15:0]   hold;
  logic [15:0]   operand, base, right, left, word;
  logic          hit;

  wire wide   = (res_sel == 2'd1);
  wire accept = raw_vld && !busy;
  wire finish = busy && (cnt == '0);
  wire load   = (accept && !corr_en) || finish;

  assign operand = wide ? raw_data : {4'b0, raw_data[11:0]};

  function automatic logic [15:0] correct(input logic [15:0] x, input logic [11:0] off,
                                           input logic [11:0] g, input logic w);
    logic signed [17:0] d;
    logic [29:0]        p;
    logic [18:0]        q;
    logic [18:0]        mx;
    d  = $signed({2'b00, x}) - $signed({{6{off[11]}}, off});
    mx = w ? 19'h0FFFF : 19'h00FFF;
    if (d < 0) return 16'h0;
    p = {13'b0, d[16:0]} * {18'b0, g};
    q = p[29:GAIN_FRAC];
    return (q > mx) ? mx[15:0] : q[15:0];
  endfunction

  assign base = busy ? correct(hold, corr_off, corr_gain, wide) : operand;

  always_comb begin
    case (res_sel)
      2'd2:    right = {2'b0, base[15:2]};
      2'd3:    right = {4'b0, base[15:4]};
      default: right = base;
    endcase
    case (res_sel)
      2'd0:    left = {right[11:0], 4'b0};
      2'd2:    left = {right[9:0], 6'b0};
      2'd3:    left = {right[7:0], 8'b0};
      default: left = right;
    endcase
    word = left_adj ? left : right;
    case (win_mode)
      3'd1:    hit = right > win_lo;
      3'd2:    hit = right < win_hi;
      3'd3:    hit = (win_lo < right) && (right < win_hi);
      3'd4:    hit = (win_hi < right) && (right < win_lo);
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      hold     <= '0;
      res_vld  <= 1'b0;
      res_data <= '0;
      win_hit  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      overrun <= raw_vld && busy;
      res_vld <= load;
      win_hit <= load && hit;
      if (load) res_data <= word;
      if (accept && corr_en) begin
        busy <= 1'b1;
        cnt  <= CW'(CORR_LAT - 1);
        hold <= operand;
      end else if (busy) begin
        if (finish) busy <= 1'b0;
        else        cnt  <= cnt - 1'b1;
      end
    end
  end

  a_r11_hit_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> res_vld);

  a_r9_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> ($past(win_mode) != 3'd0 && $past(win_mode) < 3'd5));

  a_r2_direct_result: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vld && !busy && !corr_en) |=> res_vld);

  a_r6_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vld && !busy && corr_en) |=> !res_vld);

  a_r4_left_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(left_adj) && $past(res_sel) == 2'd0) |-> res_data[3:0] == 4'h0);

  a_r3_narrow_width: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !$past(left_adj) && $past(res_sel) == 2'd3) |-> res_data[15:8] == 8'h00);

  a_r10_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(raw_vld));

endmodule

// File: tb/adc_result_conditioner_test.sv
module adc_result_conditioner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raw_vld = 1'b0;
  logic [15:0] raw_data = '0;
  logic [2:0]  win_mode = '0;
  logic [1:0]  res_sel = '0;
  logic        corr_en = 1'b0, left_adj = 1'b0;
  logic [11:0] corr_gain = 12'h800, corr_off = '0;
  logic [15:0] win_lo = '0, win_hi = '0;
  logic [15:0] res_data;
  logic        res_vld, win_hit, overrun;
  int n_chk = 0, n_bad = 0;

  adc_result_conditioner uut (
    .clk(clk), .rst_n(rst_n), .raw_vld(raw_vld), .raw_data(raw_data),
    .win_mode(win_mode), .res_sel(res_sel), .corr_en(corr_en), .left_adj(left_adj),
    .corr_gain(corr_gain), .corr_off(corr_off), .win_lo(win_lo), .win_hi(win_hi),
    .res_data(res_data), .res_vld(res_vld), .win_hit(win_hit), .overrun(overrun));

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_corr(logic [15:0] x, logic [11:0] off, logic [11:0] g, bit w);
    int o = off[11] ? int'(off) - 4096 : int'(off);
    int d = int'(x) - o;
    longint q;
    longint mx = w ? 65535 : 4095;
    if (d < 0) return 16'h0;
    q = (longint'(d) * longint'(g)) / 2048;
    return (q > mx) ? 16'(mx) : 16'(q);
  endfunction

  task automatic plain(string req, logic [15:0] raw, logic [15:0] exp, logic exp_hit);
    @(negedge clk); raw_vld = 1'b1; raw_data = raw;
    @(negedge clk); raw_vld = 1'b0;
    check({req, " vld"}, 32'(res_vld), 1);
    check({req, " data"}, 32'(res_data), 32'(exp));
    check({req, " hit"}, 32'(win_hit), 32'(exp_hit));
    @(negedge clk);
    check("R11 hit idle", 32'(win_hit), 0);
  endtask

  task automatic corr(string req, logic [15:0] raw, logic [15:0] exp);
    @(negedge clk); raw_vld = 1'b1; raw_data = raw;
    @(negedge clk); raw_vld = 1'b0;
    for (int i = 0; i < 13; i++) begin
      if (res_vld !== 1'b0) check("R6 early vld", 32'(res_vld), 0);
      @(negedge clk);
    end
    check({req, " R6 vld at 13"}, 32'(res_vld), 1);
    check({req, " data"}, 32'(res_data), 32'(exp));
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 vld", 32'(res_vld), 0);
    check("R1 data", 32'(res_data), 0);
    check("R1 hit", 32'(win_hit), 0);
    check("R1 overrun", 32'(overrun), 0);
  endtask

  task automatic t_resolution;
    res_sel = 0; plain("R2 12b", 16'hFABC, 16'h0ABC, 0);
    res_sel = 2; plain("R3 10b", 16'h0ABC, 16'h02AF, 0);
    res_sel = 3; plain("R3 8b", 16'h0ABC, 16'h00AB, 0);
    res_sel = 1; plain("R3 16b", 16'h1234, 16'h1234, 0);
  endtask

  task automatic t_left;
    left_adj = 1;
    res_sel = 0; plain("R4 12b", 16'h0ABC, 16'hABC0, 0);
    res_sel = 2; plain("R4 10b", 16'h0ABC, 16'hABC0, 0);
    res_sel = 3; plain("R4 8b", 16'h0ABC, 16'hAB00, 0);
    res_sel = 1; plain("R4 16b", 16'h1234, 16'h1234, 0);
    left_adj = 0; res_sel = 0;
  endtask

  task automatic t_corr;
    corr_en = 1;
    corr_gain = 12'h800; corr_off = 12'h010;
    corr("R5 unity", 16'h0100, ref_corr(16'h0100, 12'h010, 12'h800, 0));
    corr_gain = 12'h400; corr_off = 12'h000;
    corr("R5 half", 16'h0200, ref_corr(16'h0200, 12'h000, 12'h400, 0));
    corr_gain = 12'hFFF;
    corr("R5 sat high", 16'h0FFF, 16'h0FFF);
    corr_gain = 12'h800; corr_off = 12'h100;
    corr("R5 sat low", 16'h0050, 16'h0000);
    corr_off = 12'hFF0;
    corr("R5 neg offset", 16'h0010, 16'h0020);
    res_sel = 1; corr_gain = 12'hFFF; corr_off = 12'h000;
    corr("R5 sat 16b", 16'h9000, 16'hFFFF);
    res_sel = 0; corr_en = 0; corr_gain = 12'h800; corr_off = 0;
  endtask

  task automatic t_window;
    win_lo = 16'h0100; win_hi = 16'h0200;
    win_mode = 1; plain("R7 m1 equal", 16'h0100, 16'h0100, 0);
                  plain("R7 m1 above", 16'h0101, 16'h0101, 1);
    win_mode = 2; plain("R7 m2 equal", 16'h0200, 16'h0200, 0);
                  plain("R7 m2 below", 16'h01FF, 16'h01FF, 1);
    win_mode = 3; plain("R8 m3 in", 16'h0150, 16'h0150, 1);
                  plain("R8 m3 lo edge", 16'h0100, 16'h0100, 0);
                  plain("R8 m3 hi edge", 16'h0200, 16'h0200, 0);
    win_lo = 16'h0200; win_hi = 16'h0100;
    win_mode = 4; plain("R8 m4 in", 16'h0150, 16'h0150, 1);
                  plain("R8 m4 edge", 16'h0100, 16'h0100, 0);
    for (int m = 0; m < 8; m++) begin
      if (m >= 1 && m <= 4) continue;
      win_mode = 3'(m); plain("R9 off code", 16'h0150, 16'h0150, 0);
      win_lo = 16'h0100; win_hi = 16'h0200;
      plain("R9 off code b", 16'h0150, 16'h0150, 0);
      win_lo = 16'h0200; win_hi = 16'h0100;
    end
    left_adj = 1; res_sel = 3; win_mode = 3; win_lo = 16'h0010; win_hi = 16'h0020;
    plain("R11 right-aligned test", 16'h0150, 16'h1500, 1);
    left_adj = 0; res_sel = 0; win_mode = 0;
  endtask

  task automatic t_overrun;
    corr_en = 1; corr_gain = 12'h800; corr_off = 0;
    @(negedge clk); raw_vld = 1; raw_data = 16'h0123;
    @(negedge clk); raw_vld = 0;
    for (int i = 0; i < 13; i++) begin
      if (i == 3) begin
        raw_vld = 1; raw_data = 16'h0777;
        @(negedge clk); raw_vld = 0;
        check("R10 mid drop overrun", 32'(overrun), 1);
        check("R10 mid drop no vld", 32'(res_vld), 0);
        continue;
      end
      if (i == 12) begin raw_vld = 1; raw_data = 16'h0555; end
      @(negedge clk);
    end
    raw_vld = 0;
    check("R10 coincide vld", 32'(res_vld), 1);
    check("R10 coincide overrun", 32'(overrun), 1);
    check("R10 coincide data", 32'(res_data), 16'h0123);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (res_vld !== 1'b0) check("R10 dropped gave result", 32'(res_vld), 0);
    end
    check("R10 overrun cleared", 32'(overrun), 0);
    corr_en = 0;
    plain("R10 accepts after", 16'h0042, 16'h0042, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_resolution;
    t_left;
    t_corr;
    t_window;
    t_overrun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule